// File: doc/BRIEF.md
# Infrared Pulse Encoder and Decoder

This block sits between an asynchronous serial engine and an infrared transceiver. On the transmit side it watches the serial line level and an oversampling tick from the engine. Each zero bit becomes one short active-high pulse at the start of the bit. Each one bit leaves the output dark. The pulse width is a programmable number of oversampling periods. On the receive side a pulse from the transceiver pulls the recovered serial level low for one bit time. An optional glitch filter rejects pulses that stay high for too few clock cycles.

The engine changes `tx_line` in a cycle where `os_tick` is high, so bit boundaries coincide with ticks. `rx_pin` is assumed to be already synchronous to `clk`. When `en` is low, both directions carry the plain serial levels.

Top module: `irda_pulse_codec`

## Requirements
- R1: With `en` low, `tx_pin` equals the `tx_line` value of the previous clock cycle.
- R2: With `en` low, `rx_line` equals `rx_pin` in the same cycle.
- R3: With `en` high, a zero bit on `tx_line` gives one high pulse on `tx_pin`. The pulse starts one clock after the bit begins and lasts (`pw_code` + 1) oversampling tick periods.
- R4: With `en` high, `tx_pin` stays low for the whole of a one bit.
- R5: `ovs_mode` 0 selects 16 ticks per bit and `ovs_mode` 1 selects 8 ticks per bit. Back-to-back zero bits therefore give one pulse every 16 or every 8 tick periods.
- R6: `ovs_mode` values 2 and 3 act exactly like `ovs_mode` 0, with 16 ticks per bit.
- R7: With `en` high and `filt_en` low, any high level on `rx_pin` drives `rx_line` low in that same cycle.
- R8: With `filt_en` high, a pulse is accepted only in its fifth consecutive high cycle. A pulse of four cycles or fewer leaves `rx_line` high throughout.
- R9: Once a pulse is accepted, `rx_line` stays low until one full bit of ticks (16 or 8 per R5/R6) has passed since the pulse rose, and then returns high. A one-cycle unfiltered pulse starting on a tick cycle holds the line low for ticks-per-bit × tick period + 1 cycles.
- R10: After reset, with `en` high, `tx_line` high and `rx_pin` low, `tx_pin` is low and `rx_line` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Pulse coding enable; low means pass-through |
| pw_code | input | 2 | Transmit pulse width, code + 1 tick periods |
| filt_en | input | 1 | Receive glitch filter enable |
| ovs_mode | input | 2 | Oversampling: 1 = 8x, any other value = 16x |
| os_tick | input | 1 | One-cycle oversampling tick from the serial engine |
| tx_line | input | 1 | Serial transmit level from the engine |
| rx_pin | input | 1 | Raw pulse input from the transceiver |
| tx_pin | output | 1 | Modulated pulse output to the transceiver |
| rx_line | output | 1 | Recovered serial receive level to the engine |

## Verification
The hardest case to reach is the edge of the receive filter. A pulse of four high cycles must leave the line untouched, while a pulse of five must pull it low in exactly its fifth cycle, so the pulse length has to be controlled to the single clock. The bench aligns every pulse to a tick cycle and drives `rx_pin` for an exact number of cycles. It then counts the low cycles of `rx_line` to check both the rejection and the one-bit hold that follows an accepted pulse. Transmit pulses are checked over two back-to-back zero bits, one cycle at a time, so both the width and the repeat period are compared.

// File: rtl/irda_pulse_codec.sv
module irda_pulse_codec #(
  parameter int FILT_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pw_code,
  input  logic       filt_en,
  input  logic [1:0] ovs_mode,
  input  logic       os_tick,
  input  logic       tx_line,
  input  logic       rx_pin,
  output logic       tx_pin,
  output logic       rx_line
);
  localparam int RUNW = $clog2(FILT_LEN + 1);
  localparam logic [RUNW-1:0] RUN_MAX = RUNW'(FILT_LEN - 1);

  wire [3:0] last_ph = (ovs_mode == 2'd1) ? 4'd7 : 4'd15;

  // transmit: phase within bit, restarted on every level change
  logic       tx_q;
  logic [3:0] tx_ph, tx_ph_d;
  wire        tx_chg = tx_line ^ tx_q;

  always_comb begin
    if (tx_chg)       tx_ph_d = 4'd0;
    else if (os_tick) tx_ph_d = (tx_ph >= last_ph) ? 4'd0 : tx_ph + 4'd1;
    else              tx_ph_d = tx_ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= 1'b1;
      tx_ph  <= 4'd0;
      tx_pin <= 1'b0;
    end else begin
      tx_q   <= tx_line;
      tx_ph  <= tx_ph_d;
      tx_pin <= en ? (!tx_line && (tx_ph_d <= {2'b00, pw_code})) : tx_line;
    end
  end

  // receive: glitch filter, then hold low for one bit
  logic [RUNW-1:0] run;
  logic            det_q, hold;
  logic [3:0]      rx_ph;
  wire             det      = rx_pin && (!filt_en || run == RUN_MAX);
  wire             det_rise = det && !det_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      det_q <= 1'b0;
      hold  <= 1'b0;
      rx_ph <= 4'd0;
    end else begin
      run   <= !rx_pin ? '0 : ((run == RUN_MAX) ? run : run + 1'b1);
      det_q <= det;
      if (!en) begin
        hold <= 1'b0;
      end else if (det_rise) begin
        hold  <= 1'b1;
        rx_ph <= 4'd0;
      end else if (hold && os_tick) begin
        if (rx_ph >= last_ph) hold <= 1'b0;
        else                  rx_ph <= rx_ph + 4'd1;
      end
    end
  end

  assign rx_line = en ? !(det || hold) : rx_pin;
endmodule

// File: rtl/irda_pulse_codec_chk.sv
module irda_pulse_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic filt_en,
  input logic tx_line,
  input logic rx_pin,
  input logic tx_pin,
  input logic rx_line
);
  a_r3_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && !tx_line) && $past(tx_line, 2) |-> tx_pin);

  a_r4_dark_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && tx_line) |-> !tx_pin);

  a_r7_unfiltered_low: assert property (@(posedge clk) disable iff (!rst_n)
    en && !filt_en && rx_pin |-> !rx_line);

  a_r8_first_cycle_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    en && filt_en && $rose(rx_pin) && $past(rx_line) && $past(en) |-> rx_line);
endmodule

bind irda_pulse_codec irda_pulse_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .filt_en(filt_en),
  .tx_line(tx_line), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_line(rx_line)
);

// File: tb/irda_pulse_codec_tb.sv
`timescale 1ns/1ps
module irda_pulse_codec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [1:0] pw_code = 2'd0;
  logic       filt_en = 1'b0;
  logic [1:0] ovs_mode = 2'd0;
  logic       os_tick = 1'b0;
  logic       tx_line = 1'b1;
  logic       rx_pin = 1'b0;
  logic       tx_pin, rx_line;
  int         n_chk = 0;
  int         n_bad = 0;
  localparam int TP = 4;

  always #4 clk = ~clk;

  irda_pulse_codec u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pw_code(pw_code), .filt_en(filt_en),
    .ovs_mode(ovs_mode), .os_tick(os_tick), .tx_line(tx_line), .rx_pin(rx_pin),
    .tx_pin(tx_pin), .rx_line(rx_line)
  );

  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc = (tc + 1) % TP;
      os_tick = (tc == 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do begin @(posedge clk); #2; end while (!os_tick);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_pin == 1'b0, "R10 tx_pin after reset", tx_pin, 0);
    check(rx_line == 1'b1, "R10 rx_line after reset", rx_line, 1);
  endtask

  // R3/R5/R6: two back-to-back zero bits, checked cycle by cycle
  task automatic t_pulse(input logic [1:0] ovs, input logic [1:0] pw, input int nph, input string req);
    ovs_mode = ovs; pw_code = pw;
    repeat (10) @(posedge clk);
    wait_tick();
    tx_line = 1'b0;
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      int bad = 0, high = 0;
      for (int i = 0; i < nph * TP; i++) begin
        bit exp;
        @(negedge clk);
        exp = (i < (int'(pw) + 1) * TP);
        if (tx_pin) high++;
        if (tx_pin != exp) bad++;
      end
      check(bad == 0, req, high, (int'(pw) + 1) * TP);
    end
    wait_tick();
    tx_line = 1'b1;
    repeat (80) @(posedge clk);
  endtask

  task automatic t_ones();
    int high = 0;
    ovs_mode = 2'd0; pw_code = 2'd3;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (tx_pin) high++;
    end
    check(high == 0, "R4 one bits stay dark", high, 0);
  endtask

  task automatic t_disabled();
    @(posedge clk); #2;
    en = 1'b0; tx_line = 1'b0; rx_pin = 1'b1;
    @(negedge clk);
    check(rx_line == 1'b1, "R2 rx pass-through high", rx_line, 1);
    @(negedge clk);
    check(tx_pin == 1'b0, "R1 tx pass-through low", tx_pin, 0);
    @(posedge clk); #2;
    tx_line = 1'b1; rx_pin = 1'b0;
    @(negedge clk);
    check(rx_line == 1'b0, "R2 rx pass-through low", rx_line, 0);
    @(negedge clk);
    check(tx_pin == 1'b1, "R1 tx pass-through high", tx_pin, 1);
    @(posedge clk); #2;
    en = 1'b1;
    repeat (80) @(posedge clk);
  endtask

  // R7/R9: one-cycle unfiltered pulse
  task automatic t_rx_plain(input logic [1:0] ovs, input int nph);
    int low = 0;
    filt_en = 1'b0; ovs_mode = ovs;
    wait_tick();
    rx_pin = 1'b1;
    @(negedge clk);
    check(rx_line == 1'b0, "R7 unfiltered pulse seen at once", rx_line, 0);
    @(posedge clk); #2;
    rx_pin = 1'b0;
    for (int i = 1; i < nph * TP + 10; i++) begin
      @(negedge clk);
      if (!rx_line) low++;
    end
    check(low + 1 == nph * TP + 1, "R9 hold length", low + 1, nph * TP + 1);
    check(rx_line == 1'b1, "R9 line back high", rx_line, 1);
    repeat (10) @(posedge clk);
  endtask

  task automatic rx_burst(input int len, output int first_low);
    first_low = -1;
    wait_tick();
    rx_pin = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (!rx_line && first_low < 0) first_low = k;
    end
    @(posedge clk); #2;
    rx_pin = 1'b0;
  endtask

  task automatic t_rx_filter();
    int fl, low = 0;
    filt_en = 1'b1; ovs_mode = 2'd0;
    rx_burst(4, fl);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rx_line) low++;
    end
    check(fl < 0 && low == 0, "R8 four-cycle pulse rejected", fl, -1);
    rx_burst(5, fl);
    check(fl == 4, "R8 accepted in fifth high cycle", fl, 4);
    repeat (100) @(negedge clk);
    check(rx_line == 1'b1, "R9 line back high after filtered pulse", rx_line, 1);
    filt_en = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_ones();
    t_pulse(2'd0, 2'd0, 16, "R3 16x width 1");
    t_pulse(2'd0, 2'd3, 16, "R3 16x width 4");
    t_pulse(2'd1, 2'd1, 8,  "R5 8x width 2");
    t_pulse(2'd2, 2'd2, 16, "R6 mode 2 acts as 16x");
    t_pulse(2'd3, 2'd0, 16, "R6 mode 3 acts as 16x");
    t_disabled();
    t_rx_plain(2'd0, 16);
    t_rx_plain(2'd1, 8);
    t_rx_filter();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule